// File: doc/BRIEF.md
# Compressed Capability Permission Legalizer

This block takes the 5-bit compressed permission field of a 32-bit capability and returns the closest legal permission set under a requester-supplied restriction. The field is split into a 2-bit quadrant (field bits 4:3) and a 3-bit code (field bits 2:0). The block expands the field into seven individual flags: read, write, capability, load-mutable, execute, system-register access and mode. It ANDs those flags with a 6-bit keep mask and a mode-keep bit, and then enforces the dependency rules between permissions. Finally it packs the result back into a compressed field that is never a reserved pattern.

A permission-restricting operation uses the block when it narrows a capability. A capability load uses it to take away write and load-mutable when the authorising capability lacks load-mutable. In that case the load simply clears those two bits in the keep mask. All rules settle within one combinational pass. A parameter adds an output register, which gives one cycle of latency.

Flag and mask bit order: bit 0 read, bit 1 write, bit 2 capability, bit 3 load-mutable, bit 4 execute, bit 5 system-register access.

Top module: `cperm_legalizer`

## Requirements
- R1: Legal input fields decode as follows:
  - 0x00: nothing.
  - 0x01: read.
  - 0x04: write.
  - 0x05: read and write.
  - 0x08 and 0x09: all six flags. Field bit 0 is the mode.
  - 0x0A and 0x0B: read, capability, load-mutable and execute, plus mode.
  - 0x0C and 0x0D: the 0x0A set plus write.
  - 0x0E and 0x0F: read, write and execute, plus mode.
  - 0x13: read and capability.
  - 0x1B: read, capability and load-mutable.
  - 0x1F: read, write, capability and load-mutable.
- R2: Every other input field is reserved. It decodes as no permissions, and the result is field 0x00 with mode 0.
- R3: A flag whose mask bit is 0 is absent from the output flags.
- R4: Capability and execute are cleared when read is absent. Capability also needs read or write to survive.
- R5: Load-mutable is cleared unless capability remains. Write is cleared when capability remains without load-mutable.
- R6: Mode is cleared unless execute remains. Mode is also cleared when mode_keep is 0.
- R7: System-register access survives only when read, write, capability, load-mutable and execute all remain.
- R8: Execute is cleared when read and execute remain but both capability and write are absent.
- R9: If the rules still leave a set that cannot be encoded, flags are dropped one at a time in the priority order system-register access, execute, load-mutable, write, capability, read, re-applying the rules after each drop. Read, capability and execute without load-mutable therefore yields 0x13.
- R10: The output field is never reserved, and the output flags and mode equal the decode of the output field.
- R11: With a full mask and mode_keep at 1, inputs 0x08 and 0x09 come back unchanged, with all six flags set.
- R12: With REG_OUT=1, outputs follow the inputs one clock later. While reset is asserted the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_in | input | 5 | Compressed permission field to restrict |
| mode_keep | input | 1 | 1 keeps the mode bit, 0 clears it |
| mask_in | input | 6 | Keep mask for the six permission flags |
| perm_out | output | 5 | Legal compressed field after restriction |
| mode_out | output | 1 | Resulting mode bit |
| flags_out | output | 6 | Decoded flags of the result |

## Verification
The assertions check on every cycle the invariants of the settled set:
- the dependency rules in R4 to R8;
- the mask containment in R3;
- round-trip agreement between the output field and its flags in R10;
- the narrow use of the fallback path in R9;
- the one-cycle register relation in R12.

The exact decode table, the treatment of reserved inputs and the specific field chosen for each case can only be shown by the bench scenarios. The bench compares against a model that iterates the rules in listed order until they stop changing, and that picks the encoding by searching all 32 field values.

// File: rtl/cperm_pkg.sv
package cperm_pkg;

  localparam int QUAD_W  = 2;
  localparam int CODE_W  = 3;
  localparam int FIELD_W = QUAD_W + CODE_W;
  localparam int NPERM   = 6;

  // bit 0 = read ... bit 5 = system-register access
  typedef struct packed {
    logic asr;
    logic x;
    logic lm;
    logic c;
    logic w;
    logic r;
  } perm_flags_t;

  typedef struct packed {
    logic        mode;
    perm_flags_t f;
  } perm_set_t;

  typedef struct packed {
    logic        valid;
    perm_set_t   s;
  } perm_dec_t;

  function automatic perm_dec_t cp_decode(input logic [FIELD_W-1:0] fld);
    perm_dec_t d;
    logic [QUAD_W-1:0] q;
    logic [CODE_W-1:0] e;
    q = fld[FIELD_W-1:CODE_W];
    e = fld[CODE_W-1:0];
    d = '0;
    unique case (q)
      2'd0: begin
        if (e[1] == 1'b0 && e != 3'd2) begin
          d.valid  = ~e[1];
          d.s.f.r  = e[0];
          d.s.f.w  = e[2];
        end
      end
      2'd1: begin
        d.valid  = 1'b1;
        d.s.mode = e[0];
        d.s.f.x  = 1'b1;
        d.s.f.r  = 1'b1;
        unique case (e[2:1])
          2'd0: begin d.s.f.w = 1'b1; d.s.f.c = 1'b1; d.s.f.lm = 1'b1; d.s.f.asr = 1'b1; end
          2'd1: begin d.s.f.c = 1'b1; d.s.f.lm = 1'b1; end
          2'd2: begin d.s.f.w = 1'b1; d.s.f.c = 1'b1; d.s.f.lm = 1'b1; end
          default: begin d.s.f.w = 1'b1; end
        endcase
      end
      2'd2: begin
        if (e == 3'd3) begin
          d.valid = 1'b1;
          d.s.f.r = 1'b1;
          d.s.f.c = 1'b1;
        end
      end
      default: begin
        if (e == 3'd3 || e == 3'd7) begin
          d.valid  = 1'b1;
          d.s.f.r  = 1'b1;
          d.s.f.c  = 1'b1;
          d.s.f.lm = 1'b1;
          d.s.f.w  = e[2];
        end
      end
    endcase
    return d;
  endfunction

  // one pass in dependency order reaches the fixed point
  function automatic perm_set_t cp_apply_rules(input perm_set_t p);
    perm_set_t o;
    o = p;
    o.f.c   = o.f.c & (o.f.r | o.f.w);
    o.f.c   = o.f.c & o.f.r;
    o.f.x   = o.f.x & o.f.r;
    o.f.lm  = o.f.lm & o.f.c;
    o.f.w   = o.f.w & ~(o.f.c & ~o.f.lm);
    o.f.x   = o.f.x & ~(o.f.r & ~o.f.c & ~o.f.w);
    o.mode  = o.mode & o.f.x;
    o.f.asr = o.f.asr & o.f.r & o.f.w & o.f.c & o.f.lm & o.f.x;
    return o;
  endfunction

  // returns valid bit and field; valid=0 when no legal code exists
  function automatic logic [FIELD_W:0] cp_encode(input perm_set_t p);
    logic [FIELD_W-1:0] fld;
    logic ok;
    ok  = 1'b1;
    fld = '0;
    if (p.f.x) begin
      if (p.f.asr && p.f.r && p.f.w && p.f.c && p.f.lm)
        fld = {2'd1, 2'd0, p.mode};
      else if (!p.f.asr && p.f.r && p.f.c && p.f.lm && p.f.w)
        fld = {2'd1, 2'd2, p.mode};
      else if (!p.f.asr && p.f.r && p.f.c && p.f.lm && !p.f.w)
        fld = {2'd1, 2'd1, p.mode};
      else if (!p.f.asr && p.f.r && p.f.w && !p.f.c && !p.f.lm)
        fld = {2'd1, 2'd3, p.mode};
      else
        ok = 1'b0;
    end else if (p.mode || p.f.asr) begin
      ok = 1'b0;
    end else if (p.f.c) begin
      if (p.f.r && p.f.lm)
        fld = {2'd3, p.f.w, 2'b11};
      else if (p.f.r && !p.f.w)
        fld = {2'd2, 3'd3};
      else
        ok = 1'b0;
    end else if (p.f.lm) begin
      ok = 1'b0;
    end else begin
      fld = {2'd0, p.f.w, 1'b0, p.f.r};
    end
    return {ok, fld};
  endfunction

  function automatic perm_set_t cp_drop_one(input perm_set_t p);
    perm_set_t o;
    o = p;
    if (o.f.asr)     o.f.asr = 1'b0;
    else if (o.f.x)  o.f.x   = 1'b0;
    else if (o.f.lm) o.f.lm  = 1'b0;
    else if (o.f.w)  o.f.w   = 1'b0;
    else if (o.f.c)  o.f.c   = 1'b0;
    else             o.f.r   = 1'b0;
    return o;
  endfunction

endpackage

// File: rtl/cperm_decode.sv
module cperm_decode
  import cperm_pkg::*;
(
  input  logic [FIELD_W-1:0] fld_i,
  input  logic               mode_keep_i,
  input  logic [NPERM-1:0]   mask_i,
  output perm_set_t          masked_o,
  output logic               reserved_o
);
  perm_dec_t dec;

  always_comb begin
    dec        = cp_decode(fld_i);
    reserved_o = ~dec.valid;
    masked_o.f = dec.s.f & perm_flags_t'(mask_i);
    masked_o.mode = dec.s.mode & mode_keep_i;
  end
endmodule

// File: rtl/cperm_rules.sv
module cperm_rules
  import cperm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  perm_set_t raw_i,
  output perm_set_t legal_o,
  output logic      rule_hit_o,
  output logic      fallback_o
);
  perm_set_t first_pass;
  logic [FIELD_W:0] probe;

  always_comb begin
    perm_set_t p;
    logic [FIELD_W:0] t;
    first_pass = cp_apply_rules(raw_i);
    probe      = cp_encode(first_pass);
    p          = first_pass;
    for (int i = 0; i < NPERM; i++) begin
      t = cp_encode(p);
      if (!t[FIELD_W]) p = cp_apply_rules(cp_drop_one(p));
    end
    legal_o    = p;
    rule_hit_o = (first_pass != raw_i);
    fallback_o = ~probe[FIELD_W];
  end

  // R4: capability and execute need read
  assert_cap_exec_need_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_o.f.c | legal_o.f.x) |-> legal_o.f.r);
  // R5: load-mutable needs capability, capability without LM forbids write
  assert_lm_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_o.f.lm |-> legal_o.f.c) and ((legal_o.f.c & ~legal_o.f.lm) |-> ~legal_o.f.w));
  // R6: mode only with execute
  assert_mode_needs_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    legal_o.mode |-> legal_o.f.x);
  // R7: system access only with all others
  assert_asr_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    legal_o.f.asr |-> (legal_o.f.r & legal_o.f.w & legal_o.f.c & legal_o.f.lm & legal_o.f.x));
  // R8: bare read+execute never survives
  assert_bare_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_o.f.x & legal_o.f.r) |-> (legal_o.f.c | legal_o.f.w));
  // R9: fallback only for read+cap+execute lacking LM, and it lands on read+cap
  assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_o |-> (first_pass.f.x && first_pass.f.c && !first_pass.f.lm &&
                    legal_o.f == 6'b000101 && !legal_o.mode));
endmodule

// File: rtl/cperm_encode.sv
module cperm_encode
  import cperm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  perm_set_t          set_i,
  output logic [FIELD_W-1:0] fld_o,
  output logic               enc_ok_o
);
  logic [FIELD_W:0] packed_res;
  perm_dec_t        back;

  always_comb begin
    packed_res = cp_encode(set_i);
    fld_o      = packed_res[FIELD_W-1:0];
    enc_ok_o   = packed_res[FIELD_W];
    back       = cp_decode(fld_o);
  end

  // R10: produced code is legal and decodes back to the same set
  assert_roundtrip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_ok_o |-> (back.valid && back.s == set_i));
  assert_always_encodable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_ok_o);
endmodule

// File: rtl/cperm_legalizer.sv
module cperm_legalizer
  import cperm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] perm_in,
  input  logic               mode_keep,
  input  logic [NPERM-1:0]   mask_in,
  output logic [FIELD_W-1:0] perm_out,
  output logic               mode_out,
  output logic [NPERM-1:0]   flags_out
);
  perm_set_t          masked_set;
  perm_set_t          legal_set;
  logic               in_reserved;
  logic               rule_hit;
  logic               fallback_hit;
  logic [FIELD_W-1:0] enc_fld;
  logic               enc_ok;

  cperm_decode u_dec (
    .fld_i      (perm_in),
    .mode_keep_i(mode_keep),
    .mask_i     (mask_in),
    .masked_o   (masked_set),
    .reserved_o (in_reserved)
  );

  cperm_rules u_rules (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (masked_set),
    .legal_o   (legal_set),
    .rule_hit_o(rule_hit),
    .fallback_o(fallback_hit)
  );

  cperm_encode u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (legal_set),
    .fld_o   (enc_fld),
    .enc_ok_o(enc_ok)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          perm_out  <= '0;
          mode_out  <= 1'b0;
          flags_out <= '0;
        end else begin
          perm_out  <= enc_fld;
          mode_out  <= legal_set.mode;
          flags_out <= legal_set.f;
        end
      end
      // R12: one-cycle relation between combinational result and ports
      assert_reg_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (perm_out == $past(enc_fld) && mode_out == $past(legal_set.mode)));
    end else begin : g_comb
      assign perm_out  = enc_fld;
      assign mode_out  = legal_set.mode;
      assign flags_out = legal_set.f;
    end
  endgenerate

  // R3: nothing outside the keep mask survives
  assert_mask_contain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_set.f & ~perm_flags_t'(mask_in)) == '0);
  // R2: reserved input yields no permissions
  assert_reserved_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_reserved |-> (legal_set == '0 && !rule_hit && enc_ok));
endmodule

// File: tb/sim_cperm_legalizer.sv
`timescale 1ns/1ps
module sim_cperm_legalizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] perm_in = '0;
  logic       mode_keep = 1'b0;
  logic [5:0] mask_in = '0;
  logic [4:0] perm_out;
  logic       mode_out;
  logic [5:0] flags_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cperm_legalizer #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .perm_in(perm_in), .mode_keep(mode_keep),
    .mask_in(mask_in), .perm_out(perm_out), .mode_out(mode_out), .flags_out(flags_out)
  );

  // model: returns {valid, mode, flags[5:0]}; flag order asr,x,lm,c,w,r
  function automatic logic [7:0] m_dec(input logic [4:0] f);
    case (f)
      5'h00: return 8'b1_0_000000;
      5'h01: return 8'b1_0_000001;
      5'h04: return 8'b1_0_000010;
      5'h05: return 8'b1_0_000011;
      5'h08, 5'h09: return {1'b1, f[0], 6'b111111};
      5'h0A, 5'h0B: return {1'b1, f[0], 6'b011101};
      5'h0C, 5'h0D: return {1'b1, f[0], 6'b011111};
      5'h0E, 5'h0F: return {1'b1, f[0], 6'b010011};
      5'h13: return 8'b1_0_000101;
      5'h1B: return 8'b1_0_001101;
      5'h1F: return 8'b1_0_001111;
      default: return 8'b0;
    endcase
  endfunction

  // rules applied in listed order, repeated until nothing changes; {mode, flags}
  function automatic logic [6:0] m_rules(input logic [6:0] s);
    logic [6:0] prev;
    logic r, w, c, lm, x, a, m;
    do begin
      prev = s;
      {m, a, x, lm, c, w, r} = s;
      if (!(r || w)) c = 0;
      if (!x) m = 0;
      if (!c) lm = 0;
      if (!(r && w && c && lm && x)) a = 0;
      if (!r) begin c = 0; x = 0; end
      if (c && !lm) w = 0;
      if (x && r && !c && !w) x = 0;
      s = {m, a, x, lm, c, w, r};
    end while (s != prev);
    return s;
  endfunction

  // search for a code; returns {found, code}
  function automatic logic [5:0] m_find(input logic [6:0] s);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] d;
      d = m_dec(5'(k));
      if (d[7] && d[6:0] == s) return {1'b1, 5'(k)};
    end
    return 6'b0;
  endfunction

  // expected {field, mode, flags}
  function automatic logic [11:0] m_expect(input logic [4:0] f, input logic mk, input logic [5:0] mask);
    logic [7:0] d;
    logic [6:0] s;
    logic [5:0] hit;
    d = m_dec(f);
    s = {d[6] & mk, d[5:0] & mask};
    s = m_rules(s);
    hit = m_find(s);
    while (!hit[5]) begin
      if (s[5]) s[5] = 0;
      else if (s[4]) s[4] = 0;
      else if (s[3]) s[3] = 0;
      else if (s[1]) s[1] = 0;
      else if (s[2]) s[2] = 0;
      else s[0] = 0;
      s = m_rules(s);
      hit = m_find(s);
    end
    return {hit[4:0], s};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got field=%h mode=%b flags=%b, expected field=%h mode=%b flags=%b",
               req, act[11:7], act[6], act[5:0], exp[11:7], exp[6], exp[5:0]);
    end
  endtask

  // apply at negedge, sample at the following negedge (one register)
  task automatic run(input string req, input logic [4:0] f, input logic mk,
                     input logic [5:0] mask, input logic [11:0] exp);
    perm_in = f; mode_keep = mk; mask_in = mask;
    @(negedge clk);
    chk(req, {perm_out, mode_out, flags_out}, exp);
  endtask

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    perm_in = 5'h08; mode_keep = 1; mask_in = 6'h3F;
    repeat (3) @(negedge clk);
    // R12: outputs held at zero in reset
    chk("R12 reset", {perm_out, mode_out, flags_out}, 12'h000);
    rst_n = 1;
    @(negedge clk);

    // R11: all-permissions codes pass through
    run("R11 0x08", 5'h08, 1, 6'h3F, {5'h08, 1'b0, 6'h3F});
    run("R11 0x09", 5'h09, 1, 6'h3F, {5'h09, 1'b1, 6'h3F});
    // R12: latency, output still old just after input change
    perm_in = 5'h01; #1;
    chk("R12 latency", {perm_out, mode_out, flags_out}, {5'h09, 1'b1, 6'h3F});
    @(negedge clk);
    chk("R12 update", {perm_out, mode_out, flags_out}, {5'h01, 1'b0, 6'h01});

    // R1 and R2: every field, full mask, both mode_keep values
    for (int k = 0; k < 32; k++) begin
      logic [7:0] d;
      d = m_dec(5'(k));
      run(d[7] ? "R1 decode" : "R2 reserved", 5'(k), 1, 6'h3F,
          d[7] ? {5'(k), d[6:0]} : 12'h000);
      run("R6 mode_keep", 5'(k), 0, 6'h3F, m_expect(5'(k), 0, 6'h3F));
    end

    // directed rules
    run("R4 drop read", 5'h1F, 1, 6'h3E, {5'h04, 1'b0, 6'h02});
    run("R5 drop LM", 5'h1F, 1, 6'h37, {5'h13, 1'b0, 6'h05});
    run("R6 drop exec", 5'h0B, 1, 6'h2F, {5'h1B, 1'b0, 6'h0D});
    run("R6 clear mode", 5'h09, 0, 6'h3F, {5'h08, 1'b0, 6'h3F});
    run("R7 drop write", 5'h08, 1, 6'h3D, {5'h0A, 1'b0, 6'h1D});
    run("R8 bare exec", 5'h0E, 1, 6'h3D, {5'h01, 1'b0, 6'h01});
    run("R9 fallback", 5'h0A, 1, 6'h37, {5'h13, 1'b0, 6'h05});
    run("R9 fallback mode", 5'h0B, 1, 6'h17, {5'h13, 1'b0, 6'h05});
    run("R3 empty mask", 5'h08, 1, 6'h00, {5'h00, 1'b0, 6'h00});

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] f;
      logic mk;
      logic [5:0] mask;
      f = 5'($urandom);
      mk = 1'($urandom);
      mask = 6'($urandom);
      if (i % 4 == 0) f = 5'h08 | 5'($urandom_range(0, 7));
      run("R3 random", f, mk, mask, m_expect(f, mk, mask));
      total++;
      if ((flags_out & ~mask) != 0 || !m_dec(perm_out)[7] ||
          m_dec(perm_out)[6:0] != {mode_out, flags_out}) begin
        bad++;
        $display("FAIL R10: got field=%h flags=%b, expected legal consistent code", perm_out, flags_out);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule